// File: doc/BRIEF.md
# Type B Start-of-Frame and Character Deframer

This block sits behind a proximity-card reader's subcarrier demodulator. It takes one signed soft decision per sample strobe, at two samples per elementary time unit (ETU), and turns the stream into bytes. A strictly positive sample value is a logic 1. A zero or negative value is a logic 0.

The deframer first needs carrier activity, which is a high sample. It then waits a bounded time for the start-of-frame low phase, and it checks both the low phase and the following high phase against separate acceptance windows. After a valid start of frame it decodes asynchronous characters. Each character has a low start bit, eight data bits sent least significant bit first, and a stop bit. Any number of high samples may separate characters. A character whose stop bit is low marks the end of the frame.

Completed bytes come out as one-cycle strobes. A one-cycle frame-done pulse follows once the frame has ended. A one-cycle frame-error pulse reports a frame that carries more bytes than the configured limit. A level output shows that the start of frame has been recognised.

Top module: `typeb_deframer`

## Requirements
- R1: Only clock cycles with `smp_valid` high advance the deframer. A sample counts as 1 when `smp_val` is strictly positive and as 0 when it is zero or negative. Output pulses appear in the cycle after the sample edge that caused them.
- R2: From the unsynchronised state, a 1 sample arms the deframer. While armed, 52 consecutive 1 samples, counting the arming one, are tolerated. A 53rd 1 sample returns the deframer to unsynchronised. A 0 sample while armed begins the start-of-frame low phase.
- R3: If the start-of-frame low phase ends after fewer than 16 samples of 0, it is rejected and the deframer becomes unsynchronised. A low phase of 16 samples or more is accepted.
- R4: A 29th consecutive 0 sample in the start-of-frame low phase aborts the frame. A low phase of 28 samples is still accepted.
- R5: After an accepted low phase, at most 4 samples of 1 may occur before the 0 that starts the first character. A 5th sample of 1 returns the deframer to unsynchronised.
- R6: `sof_seen` rises on the sample edge of the first 1 that ends an accepted low phase. It falls whenever the deframer becomes unsynchronised, including at the end of a frame.
- R7: A character occupies 10 ETU (20 samples). Each bit is taken from the second sample of its ETU. Data bits are assembled with the least significant bit first. A stop bit of 1 gives a one-cycle `byte_valid` pulse, with the byte on `byte_data`.
- R8: Between characters, any number of 1 samples, including none, may occur. The next 0 sample starts the next character.
- R9: A character with a stop bit of 0 ends the frame. If at least one byte was delivered, `frame_done` pulses for one cycle.
- R10: A frame that ends before any byte was delivered produces no `frame_done` and no `byte_valid`.
- R11: At most `MAX_BYTES` bytes (default 16) are delivered per frame. A further character with a stop bit of 1 is not delivered. Instead `frame_error` pulses and the deframer becomes unsynchronised.
- R12: During and after reset, `byte_valid`, `frame_done`, `frame_error`, `sof_seen` and `byte_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_val | input | SMP_W | Signed soft decision; positive means 1 |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Last completed byte |
| frame_done | output | 1 | One-cycle pulse at the end of a frame that carried bytes |
| frame_error | output | 1 | One-cycle pulse on byte-count overflow |
| sof_seen | output | 1 | Start of frame recognised |

## Verification
The bench drives every acceptance window on both sides of its limit:
- arming for 52 versus 53 samples;
- low phases of 15, 16, 28 and 29 samples;
- high phases of 4 versus 5 samples.

An off-by-one counter would accept the frame that should be refused, or refuse the one that should be accepted, and the byte count at the ports shows which happened.

Every valid sample is followed by an invalid one that carries the opposite level. A design that ignored the strobe would therefore misframe every character.

Further cases cover:
- back-to-back characters with no gap;
- an end of frame with no bytes, which must stay silent;
- a zero-valued low phase;
- a seventeenth byte with the default limit, which must raise `frame_error` and not appear as a byte.

// File: rtl/typeb_deframer_pkg.sv
package typeb_deframer_pkg;

    typedef enum logic [2:0] {
        ST_UNSYNC = 3'd0,
        ST_ARMED  = 3'd1,
        ST_SOF_LO = 3'd2,
        ST_SOF_HI = 3'd3,
        ST_CHAR   = 3'd4,
        ST_GAP    = 3'd5
    } dfr_state_e;

endpackage

// File: rtl/typeb_slicer.sv
module typeb_slicer #(
    parameter int W = 8
) (
    input  logic signed [W-1:0] val,
    output logic                bit_hi
);
    // strictly positive means logic 1; zero and negative mean logic 0
    assign bit_hi = !val[W-1] && (val != '0);
endmodule

// File: rtl/typeb_byte_shift.sv
module typeb_byte_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bit_in,
    output logic [DW-1:0] data
);
    // least significant bit arrives first: shift in at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (en) begin
            data <= {bit_in, data[DW-1:1]};
        end
    end
endmodule

// File: rtl/typeb_deframer.sv
module typeb_deframer
    import typeb_deframer_pkg::*;
#(
    parameter int SMP_W     = 8,
    parameter int SPE       = 2,
    parameter int WAIT_MAX  = 52,
    parameter int LOW_MIN   = 16,
    parameter int LOW_MAX   = 28,
    parameter int HIGH_MAX  = 4,
    parameter int MAX_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_val,
    output logic                    byte_valid,
    output logic [7:0]              byte_data,
    output logic                    frame_done,
    output logic                    frame_error,
    output logic                    sof_seen
);
    localparam int CM1  = (WAIT_MAX > LOW_MAX) ? WAIT_MAX : LOW_MAX;
    localparam int CMAX = (CM1 > HIGH_MAX) ? CM1 : HIGH_MAX;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int PW   = $clog2(SPE + 1);
    localparam int CTR  = SPE / 2;
    localparam int BW   = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        dfr_state_e    st;
        logic [CW-1:0] cnt;
        logic [PW-1:0] ph;
        logic [3:0]    etu;
        logic [BW-1:0] nbytes;
        logic          sof;
        logic          bv;
        logic [7:0]    bd;
        logic          fd;
        logic          fe;
    } dfr_regs_t;

    dfr_regs_t q, d;
    logic       bit_hi;
    logic       shift_en;
    logic [7:0] shreg;
    logic       centre;
    logic       last_ph;

    typeb_slicer #(.W(SMP_W)) u_slicer (
        .val    (smp_val),
        .bit_hi (bit_hi)
    );

    typeb_byte_shift #(.DW(8)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (shift_en),
        .bit_in (bit_hi),
        .data   (shreg)
    );

    assign centre  = (q.ph == PW'(CTR));
    assign last_ph = (q.ph == PW'(SPE - 1));

    always_comb begin
        d        = q;
        d.bv     = 1'b0;
        d.fd     = 1'b0;
        d.fe     = 1'b0;
        shift_en = 1'b0;
        if (smp_valid) begin
            case (q.st)
                ST_UNSYNC: begin
                    if (bit_hi) begin
                        d.st  = ST_ARMED;
                        d.cnt = CW'(1);
                    end
                end
                ST_ARMED: begin
                    if (!bit_hi) begin
                        d.st  = ST_SOF_LO;
                        d.cnt = CW'(1);
                    end else if (q.cnt >= CW'(WAIT_MAX)) begin
                        d.st = ST_UNSYNC;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                ST_SOF_LO: begin
                    if (!bit_hi) begin
                        if (q.cnt >= CW'(LOW_MAX)) d.st = ST_UNSYNC;
                        else                       d.cnt = q.cnt + CW'(1);
                    end else if (q.cnt < CW'(LOW_MIN)) begin
                        d.st = ST_UNSYNC;
                    end else begin
                        d.st     = ST_SOF_HI;
                        d.cnt    = CW'(1);
                        d.sof    = 1'b1;
                        d.nbytes = '0;
                    end
                end
                ST_SOF_HI: begin
                    if (bit_hi) begin
                        if (q.cnt >= CW'(HIGH_MAX)) d.st = ST_UNSYNC;
                        else                        d.cnt = q.cnt + CW'(1);
                    end else begin
                        d.st  = ST_CHAR;
                        d.ph  = PW'(1);
                        d.etu = 4'd0;
                    end
                end
                ST_GAP: begin
                    if (!bit_hi) begin
                        d.st  = ST_CHAR;
                        d.ph  = PW'(1);
                        d.etu = 4'd0;
                    end
                end
                ST_CHAR: begin
                    if (centre && (q.etu >= 4'd1) && (q.etu <= 4'd8)) shift_en = 1'b1;
                    if (last_ph) begin
                        d.ph  = '0;
                        d.etu = q.etu + 4'd1;
                    end else begin
                        d.ph = q.ph + PW'(1);
                    end
                    if (centre && (q.etu == 4'd9)) begin
                        if (!bit_hi) begin
                            d.fd = (q.nbytes != '0);
                            d.st = ST_UNSYNC;
                        end else if (q.nbytes == BW'(MAX_BYTES)) begin
                            d.fe = 1'b1;
                            d.st = ST_UNSYNC;
                        end else begin
                            d.bv     = 1'b1;
                            d.bd     = shreg;
                            d.nbytes = q.nbytes + BW'(1);
                            d.st     = ST_GAP;
                        end
                    end
                end
                default: d.st = ST_UNSYNC;
            endcase
        end
        if (d.st == ST_UNSYNC) d.sof = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_valid  = q.bv;
    assign byte_data   = q.bd;
    assign frame_done  = q.fd;
    assign frame_error = q.fe;
    assign sof_seen    = q.sof;

endmodule

// File: rtl/typeb_deframer_chk.sv
module typeb_deframer_chk #(
    parameter int SMP_W     = 8,
    parameter int MAX_BYTES = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic signed [SMP_W-1:0] smp_val,
    input logic                    byte_valid,
    input logic                    frame_done,
    input logic                    frame_error,
    input logic                    sof_seen
);
    localparam int NW = $clog2(MAX_BYTES + 2);
    logic [NW-1:0] nb;

    always_ff @(posedge clk) begin
        if (!rst_n || !sof_seen) nb <= '0;
        else if (byte_valid)     nb <= nb + NW'(1);
    end

    p_out_on_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid || frame_done || frame_error) |-> $past(smp_valid));

    p_sof_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_valid) |-> $stable(sof_seen));

    p_sof_rise_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_seen) |-> ($past(smp_valid) && !$past(smp_val[SMP_W-1]) && ($past(smp_val) != '0)));

    p_byte_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> sof_seen);

    p_done_drops_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !sof_seen);

    p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({byte_valid, frame_done, frame_error}) <= 1);

    p_err_drops_sof_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> !sof_seen);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (nb < NW'(MAX_BYTES)));

endmodule

bind typeb_deframer typeb_deframer_chk #(
    .SMP_W     (SMP_W),
    .MAX_BYTES (MAX_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_val     (smp_val),
    .byte_valid  (byte_valid),
    .frame_done  (frame_done),
    .frame_error (frame_error),
    .sof_seen    (sof_seen)
);

// File: tb/typeb_deframer_tb.sv
module typeb_deframer_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_val = '0;
    logic              byte_valid;
    logic [7:0]        byte_data;
    logic              frame_done;
    logic              frame_error;
    logic              sof_seen;

    int ntests = 0;
    int nfail  = 0;
    int nbv, nfd, nfe;
    logic [7:0] rx [32];

    always #5 clk = ~clk;

    typeb_deframer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_val     (smp_val),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .frame_done  (frame_done),
        .frame_error (frame_error),
        .sof_seen    (sof_seen)
    );

    // fields: arm[24:19] low[18:13] high[12:10] data[9:2] exp_sof[1] exp_byte[0]
    localparam logic [24:0] VEC [8] = '{
        {6'd4,  6'd20, 3'd2, 8'hA5, 1'b1, 1'b1},
        {6'd52, 6'd16, 3'd4, 8'h3C, 1'b1, 1'b1},
        {6'd53, 6'd20, 3'd2, 8'h11, 1'b0, 1'b0},
        {6'd2,  6'd15, 3'd2, 8'h22, 1'b0, 1'b0},
        {6'd2,  6'd28, 3'd1, 8'h80, 1'b1, 1'b1},
        {6'd2,  6'd29, 3'd2, 8'h44, 1'b0, 1'b0},
        {6'd2,  6'd20, 3'd5, 8'h55, 1'b1, 1'b0},
        {6'd1,  6'd20, 3'd1, 8'h01, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one valid sample, then one invalid cycle carrying the opposite level
    task automatic smpv(input logic signed [7:0] v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_val   = v;
        @(posedge clk);
        #1;
        if (byte_valid) begin
            if (nbv < 32) rx[nbv] = byte_data;
            nbv++;
        end
        if (frame_done)  nfd++;
        if (frame_error) nfe++;
        @(negedge clk);
        smp_valid = 1'b0;
        smp_val   = (v > 0) ? -8'sd90 : 8'sd90;
    endtask

    task automatic smp(input logic hi);
        smpv(hi ? 8'sd37 : -8'sd40);
    endtask

    task automatic ticks(input int n, input logic hi);
        for (int i = 0; i < n; i++) smp(hi);
    endtask

    task automatic chr(input logic [7:0] b, input logic stop);
        ticks(2, 1'b0);
        for (int j = 0; j < 8; j++) ticks(2, b[j]);
        ticks(2, stop);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        nbv = 0; nfd = 0; nfe = 0;
    endtask

    // watchdog
    initial begin
        #(10 * 100000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        // R12 reset state
        do_reset();
        chk("R12 byte_valid", byte_valid, 0);
        chk("R12 frame_done", frame_done, 0);
        chk("R12 frame_error", frame_error, 0);
        chk("R12 sof_seen", sof_seen, 0);
        chk("R12 byte_data", byte_data, 0);

        // table walk: R2 R3 R4 R5 window boundaries
        for (int i = 0; i < 8; i++) begin
            logic [24:0] v;
            v = VEC[i];
            do_reset();
            ticks(int'(v[24:19]), 1'b1);
            ticks(int'(v[18:13]), 1'b0);
            smp(1'b1);
            chk($sformatf("R6/R2/R3/R4 sof vec%0d", i), sof_seen, int'(v[1]));
            ticks(int'(v[12:10]) - 1, 1'b1);
            chr(v[9:2], 1'b1);
            chr(8'h00, 1'b0);
            ticks(8, 1'b1);
            chk($sformatf("R5/R7 bytes vec%0d", i), nbv, int'(v[0]));
            if (v[0]) chk($sformatf("R7 data vec%0d", i), rx[0], int'(v[9:2]));
            chk($sformatf("R9 done vec%0d", i), nfd, int'(v[0]));
            chk($sformatf("R11 no error vec%0d", i), nfe, 0);
        end

        // R8 multi-byte with and without gaps, R1 strobe gating, R6 clear
        do_reset();
        ticks(3, 1'b1);
        ticks(20, 1'b0);
        smp(1'b1);
        chk("R6 sof rises", sof_seen, 1);
        smp(1'b1);
        chr(8'h5A, 1'b1);
        ticks(2, 1'b1);
        chr(8'hC3, 1'b1);
        chr(8'h00, 1'b1);
        ticks(5, 1'b1);
        chr(8'hFF, 1'b1);
        chr(8'h00, 1'b0);
        chk("R8 count", nbv, 4);
        chk("R7 byte0", rx[0], 8'h5A);
        chk("R8 byte1", rx[1], 8'hC3);
        chk("R8 byte2 no gap", rx[2], 8'h00);
        chk("R1 byte3 strobe gated", rx[3], 8'hFF);
        chk("R9 done", nfd, 1);
        chk("R6 sof clears at end", sof_seen, 0);

        // R10 empty frame
        do_reset();
        ticks(2, 1'b1);
        ticks(20, 1'b0);
        ticks(2, 1'b1);
        chr(8'h00, 1'b0);
        chk("R10 no byte", nbv, 0);
        chk("R10 no done", nfd, 0);
        chk("R6 sof cleared", sof_seen, 0);

        // R1 zero-valued samples count as 0
        do_reset();
        ticks(2, 1'b1);
        for (int i = 0; i < 18; i++) smpv(8'sd0);
        smp(1'b1);
        chk("R1 zero is low", sof_seen, 1);

        // R11 overflow on the 17th byte
        do_reset();
        ticks(2, 1'b1);
        ticks(20, 1'b0);
        smp(1'b1);
        for (int k = 0; k < 17; k++) begin
            chr(8'(k + 1), 1'b1);
            ticks(2, 1'b1);
        end
        chk("R11 bytes capped", nbv, 16);
        chk("R11 last byte", rx[15], 16);
        chk("R11 error", nfe, 1);
        chk("R11 no done", nfd, 0);
        chk("R11 sof cleared", sof_seen, 0);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule